// File: doc/BRIEF.md
# Dual-Mode Floating-Point Register File

This block holds the floating-point operands of a core. It has two combinational read ports and one write port. Each port carries a register number, a precision select (single or double) and a 64-bit data bus. A mode input picks one of two views of the same storage.

With the mode input low, the file looks like 32 registers of 32 bits. A double-precision access names an even register and joins it with the odd register above it. With the mode input high, the file looks like 32 independent registers of 64 bits, and a double access may name any register.

Each storage entry holds a low word and a high word. Register n always has its low word in entry n. For that reason, switching modes never moves or clears data; only the mapping from register numbers to storage changes. A double access that names an odd register in the 32-bit view raises an illegal flag on its port, and such a write is dropped.

Top module: `fprf_mode_regfile`

## Requirements
- R1: Driving rst_ni low clears every stored word to zero at once, without waiting for a clock edge.
- R2: With mode_i=0 and the precision select at 0 (single), a read of register n returns its 32-bit word in bits 31:0, with bits 63:32 at zero. A write stores bits 31:0 of the data bus.
- R3: With mode_i=0 and the precision select at 1 (double) naming an even n, bits 31:0 map to register n and bits 63:32 map to register n+1, for both reads and writes.
- R4: With mode_i=0, a double access that names an odd register raises that port's illegal flag. An illegal read returns zero, and an illegal write changes no storage.
- R5: With mode_i=1, a double access to any register n, odd or even, reads or writes all 64 bits of register n independently of every other register.
- R6: With mode_i=1, a single write updates only bits 31:0 of the named register and keeps bits 63:32. A single read returns bits 31:0, with bits 63:32 at zero.
- R7: A read in the same cycle as a write returns the new data for every word that the write touches, including the partner word of a register pair.
- R8: A change of mode_i leaves stored data unchanged: the 32-bit register n in mode 0 is bits 31:0 of the 64-bit register n in mode 1.
- R9: Storage changes only on a rising edge of clk_i while we_i is high.
- R10: wr_illegal_o is high only when we_i is high and the write is an odd-numbered double access in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: 32 x 32-bit view, 1: 32 x 64-bit view |
| ra_idx_i | input | 5 | Read port A register number |
| ra_dbl_i | input | 1 | Read port A precision, 1 = double |
| ra_data_o | output | 64 | Read port A data |
| ra_illegal_o | output | 1 | Read port A illegal access |
| rb_idx_i | input | 5 | Read port B register number |
| rb_dbl_i | input | 1 | Read port B precision, 1 = double |
| rb_data_o | output | 64 | Read port B data |
| rb_illegal_o | output | 1 | Read port B illegal access |
| we_i | input | 1 | Write enable |
| wr_idx_i | input | 5 | Write register number |
| wr_dbl_i | input | 1 | Write precision, 1 = double |
| wr_data_i | input | 64 | Write data |
| wr_illegal_o | output | 1 | Illegal write, write dropped |

## Verification
Random traffic mixes both modes, both precisions and all register numbers. Mode changes happen between writes, so a word written in one view is later read in the other; this tells a shared mapping apart from separate per-mode storage. Same-cycle read/write collisions check the bypass, including the case where a pair write changes the partner word of a register being read, which a bypass that compares only register numbers would miss. Directed cases cover the odd-pair write, a single write over a 64-bit value, disabled writes and a reset in mid-run.

// File: rtl/fprf_pkg.sv
package fprf_pkg;
  localparam int unsigned N_REG_DEF  = 32;
  localparam int unsigned WORD_W_DEF = 32;
endpackage

// File: rtl/fprf_wr_decode.sv
module fprf_wr_decode #(
  parameter int unsigned N_REG  = fprf_pkg::N_REG_DEF,
  parameter int unsigned WORD_W = fprf_pkg::WORD_W_DEF,
  localparam int unsigned IDX_W  = $clog2(N_REG),
  localparam int unsigned DATA_W = 2 * WORD_W
) (
  input  logic                          mode_i,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic                          dbl_i,
  input  logic [DATA_W-1:0]             data_i,
  output logic [N_REG-1:0]              we_lo_o,
  output logic [N_REG-1:0]              we_hi_o,
  output logic [N_REG-1:0][WORD_W-1:0]  lo_wd_o,
  output logic [WORD_W-1:0]             hi_wd_o,
  output logic                          illegal_o
);
  logic             odd_pair;
  logic [IDX_W-1:0] pair_idx;

  assign odd_pair  = ~mode_i & dbl_i & idx_i[0];
  assign illegal_o = we_i & odd_pair;
  assign pair_idx  = idx_i | IDX_W'(1);
  assign hi_wd_o   = data_i[DATA_W-1:WORD_W];

  for (genvar k = 0; k < N_REG; k++) begin : g_ent
    logic hit, pair_hit;
    assign hit      = (idx_i == IDX_W'(k));
    // partner word of an even pair in the 32-bit view
    assign pair_hit = ~mode_i & dbl_i & ~idx_i[0] & (pair_idx == IDX_W'(k));
    assign we_lo_o[k] = we_i & ~odd_pair & (hit | pair_hit);
    assign we_hi_o[k] = we_i & mode_i & dbl_i & hit;
    assign lo_wd_o[k] = pair_hit ? data_i[DATA_W-1:WORD_W] : data_i[WORD_W-1:0];
  end
endmodule

// File: rtl/fprf_store.sv
module fprf_store #(
  parameter int unsigned N_REG  = fprf_pkg::N_REG_DEF,
  parameter int unsigned WORD_W = fprf_pkg::WORD_W_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REG-1:0]              we_lo_i,
  input  logic [N_REG-1:0]              we_hi_i,
  input  logic [N_REG-1:0][WORD_W-1:0]  lo_wd_i,
  input  logic [WORD_W-1:0]             hi_wd_i,
  output logic [N_REG-1:0][WORD_W-1:0]  lo_q_o,
  output logic [N_REG-1:0][WORD_W-1:0]  hi_q_o
);
  for (genvar k = 0; k < N_REG; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q_o[k] <= '0;
        hi_q_o[k] <= '0;
      end else begin
        if (we_lo_i[k]) lo_q_o[k] <= lo_wd_i[k];
        if (we_hi_i[k]) hi_q_o[k] <= hi_wd_i;
      end
    end
  end
endmodule

// File: rtl/fprf_rd_port.sv
module fprf_rd_port #(
  parameter int unsigned N_REG  = fprf_pkg::N_REG_DEF,
  parameter int unsigned WORD_W = fprf_pkg::WORD_W_DEF,
  localparam int unsigned IDX_W  = $clog2(N_REG),
  localparam int unsigned DATA_W = 2 * WORD_W
) (
  input  logic                          mode_i,
  input  logic [IDX_W-1:0]              idx_i,
  input  logic                          dbl_i,
  input  logic [N_REG-1:0][WORD_W-1:0]  lo_q_i,
  input  logic [N_REG-1:0][WORD_W-1:0]  hi_q_i,
  input  logic [N_REG-1:0]              we_lo_i,
  input  logic [N_REG-1:0]              we_hi_i,
  input  logic [N_REG-1:0][WORD_W-1:0]  lo_wd_i,
  input  logic [WORD_W-1:0]             hi_wd_i,
  output logic [DATA_W-1:0]             data_o,
  output logic                          illegal_o
);
  logic [IDX_W-1:0]  pair_idx;
  logic [WORD_W-1:0] w_lo, w_pair, w_hi;

  assign pair_idx  = idx_i | IDX_W'(1);
  assign illegal_o = ~mode_i & dbl_i & idx_i[0];

  // write-first: take the word being written this cycle
  assign w_lo   = we_lo_i[idx_i]    ? lo_wd_i[idx_i]    : lo_q_i[idx_i];
  assign w_pair = we_lo_i[pair_idx] ? lo_wd_i[pair_idx] : lo_q_i[pair_idx];
  assign w_hi   = we_hi_i[idx_i]    ? hi_wd_i           : hi_q_i[idx_i];

  always_comb begin
    if (illegal_o)   data_o = '0;
    else if (!dbl_i) data_o = {{WORD_W{1'b0}}, w_lo};
    else if (mode_i) data_o = {w_hi, w_lo};
    else             data_o = {w_pair, w_lo};
  end
endmodule

// File: rtl/fprf_mode_regfile.sv
module fprf_mode_regfile #(
  parameter int unsigned N_REG  = fprf_pkg::N_REG_DEF,
  parameter int unsigned WORD_W = fprf_pkg::WORD_W_DEF,
  localparam int unsigned IDX_W  = $clog2(N_REG),
  localparam int unsigned DATA_W = 2 * WORD_W,
  localparam int unsigned N_RD   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic              ra_dbl_i,
  output logic [DATA_W-1:0] ra_data_o,
  output logic              ra_illegal_o,
  input  logic [IDX_W-1:0]  rb_idx_i,
  input  logic              rb_dbl_i,
  output logic [DATA_W-1:0] rb_data_o,
  output logic              rb_illegal_o,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_dbl_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_illegal_o
);
  logic [N_REG-1:0]             we_lo, we_hi;
  logic [N_REG-1:0][WORD_W-1:0] lo_wd, lo_q, hi_q;
  logic [WORD_W-1:0]            hi_wd;

  logic [N_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [N_RD-1:0]             rd_dbl, rd_ill;
  logic [N_RD-1:0][DATA_W-1:0] rd_data;

  assign rd_idx = {rb_idx_i, ra_idx_i};
  assign rd_dbl = {rb_dbl_i, ra_dbl_i};
  assign ra_data_o    = rd_data[0];
  assign rb_data_o    = rd_data[1];
  assign ra_illegal_o = rd_ill[0];
  assign rb_illegal_o = rd_ill[1];

  fprf_wr_decode #(.N_REG(N_REG), .WORD_W(WORD_W)) u_wr (
    .mode_i(mode_i), .we_i(we_i), .idx_i(wr_idx_i), .dbl_i(wr_dbl_i),
    .data_i(wr_data_i), .we_lo_o(we_lo), .we_hi_o(we_hi),
    .lo_wd_o(lo_wd), .hi_wd_o(hi_wd), .illegal_o(wr_illegal_o)
  );

  fprf_store #(.N_REG(N_REG), .WORD_W(WORD_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_lo_i(we_lo), .we_hi_i(we_hi),
    .lo_wd_i(lo_wd), .hi_wd_i(hi_wd), .lo_q_o(lo_q), .hi_q_o(hi_q)
  );

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    fprf_rd_port #(.N_REG(N_REG), .WORD_W(WORD_W)) u_rd (
      .mode_i(mode_i), .idx_i(rd_idx[p]), .dbl_i(rd_dbl[p]),
      .lo_q_i(lo_q), .hi_q_i(hi_q), .we_lo_i(we_lo), .we_hi_i(we_hi),
      .lo_wd_i(lo_wd), .hi_wd_i(hi_wd),
      .data_o(rd_data[p]), .illegal_o(rd_ill[p])
    );
  end

  a_r4_illegal_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_illegal_o |=> ($stable(lo_q) && $stable(hi_q)));

  a_r6_single_keeps_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mode_i && !wr_dbl_i) |=> hi_q[$past(wr_idx_i)] == $past(hi_q[wr_idx_i]));

  a_r3_pair_high_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !mode_i && wr_dbl_i && !wr_idx_i[0])
      |=> lo_q[$past(wr_idx_i) | IDX_W'(1)] == $past(wr_data_i[DATA_W-1:WORD_W]));

  a_r7_bypass_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mode_i && wr_dbl_i && ra_dbl_i && ra_idx_i == wr_idx_i) |-> ra_data_o == wr_data_i);

  a_r2_single_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ra_dbl_i |-> ra_data_o[DATA_W-1:WORD_W] == '0);

  a_r10_illegal_needs_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_illegal_o |-> (we_i && !mode_i && wr_dbl_i && wr_idx_i[0]));
endmodule

// File: tb/fprf_mode_regfile_tb_top.sv
module fprf_mode_regfile_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode, ra_dbl, rb_dbl, we, wr_dbl;
  logic [4:0] ra_idx, rb_idx, wr_idx;
  logic [63:0] wr_data, ra_data, rb_data;
  logic ra_ill, rb_ill, wr_ill;

  int tests = 0;
  int fails = 0;
  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];
  logic [31:0] n_lo [32];
  logic [31:0] n_hi [32];

  always #4 clk = ~clk;

  fprf_mode_regfile dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode),
    .ra_idx_i(ra_idx), .ra_dbl_i(ra_dbl), .ra_data_o(ra_data), .ra_illegal_o(ra_ill),
    .rb_idx_i(rb_idx), .rb_dbl_i(rb_dbl), .rb_data_o(rb_data), .rb_illegal_o(rb_ill),
    .we_i(we), .wr_idx_i(wr_idx), .wr_dbl_i(wr_dbl), .wr_data_i(wr_data),
    .wr_illegal_o(wr_ill)
  );

  function automatic logic [63:0] exp_rd(logic md, logic [4:0] idx, logic dbl);
    if (!md && dbl && idx[0]) return 64'h0;
    if (!dbl) return {32'h0, n_lo[idx]};
    if (md) return {n_hi[idx], n_lo[idx]};
    return {n_lo[idx | 5'd1], n_lo[idx]};
  endfunction

  function automatic string tag_of(logic md, logic [4:0] idx, logic dbl);
    if (we && ((wr_idx == idx) || ((wr_idx | 5'd1) == (idx | 5'd1) && !md))) return "R7";
    if (!md && dbl && idx[0]) return "R4";
    if (!md) return dbl ? "R3" : "R2";
    return dbl ? "R5" : "R6";
  endfunction

  task automatic check(logic [63:0] act, logic [63:0] exp, string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write();
    if (!we) return;
    if (!mode && wr_dbl && wr_idx[0]) return;
    n_lo[wr_idx] = wr_data[31:0];
    if (wr_dbl) begin
      if (mode) n_hi[wr_idx] = wr_data[63:32];
      else      n_lo[wr_idx | 5'd1] = wr_data[63:32];
    end
  endtask

  task automatic step(logic md, logic [4:0] ai, logic ad, logic [4:0] bi, logic bd,
                      logic w, logic [4:0] wi, logic wd, logic [63:0] dat, string tag);
    @(negedge clk);
    mode = md; ra_idx = ai; ra_dbl = ad; rb_idx = bi; rb_dbl = bd;
    we = w; wr_idx = wi; wr_dbl = wd; wr_data = dat;
    n_lo = m_lo; n_hi = m_hi;
    model_write();
    #1;
    check(ra_data, exp_rd(md, ai, ad), tag != "" ? tag : tag_of(md, ai, ad));
    check(rb_data, exp_rd(md, bi, bd), tag != "" ? tag : tag_of(md, bi, bd));
    check({63'h0, ra_ill}, {63'h0, !md && ad && ai[0]}, "R4");
    check({63'h0, rb_ill}, {63'h0, !md && bd && bi[0]}, "R4");
    check({63'h0, wr_ill}, {63'h0, w && !md && wd && wi[0]}, "R10");
    @(posedge clk);
    m_lo = n_lo; m_hi = n_hi;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    n_lo = m_lo; n_hi = m_hi;
    mode = 1'b1; ra_dbl = 1'b1; rb_dbl = 1'b1; we = 1'b0; wr_dbl = 1'b0;
    ra_idx = '0; rb_idx = '0; wr_idx = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    for (int i = 0; i < 32; i++) begin
      ra_idx = 5'(i); #1;
      check(ra_data, 64'h0, "R1");
    end
    @(negedge clk); rst_ni = 1'b1;

    // R5: odd 64-bit registers are independent
    step(1, 0, 0, 0, 0, 1, 5'd3, 1, 64'hAAAA_0003_BBBB_0003, "");
    step(1, 0, 0, 0, 0, 1, 5'd4, 1, 64'hCCCC_0004_DDDD_0004, "");
    step(1, 5'd3, 1, 5'd4, 1, 0, 0, 0, 64'h0, "R5");
    // R3: even pair write, halves read as singles
    step(0, 0, 0, 0, 0, 1, 5'd10, 1, 64'h1111_2222_3333_4444, "");
    step(0, 5'd10, 0, 5'd11, 0, 0, 0, 0, 64'h0, "R3");
    // R4: odd pair write dropped
    step(0, 0, 0, 0, 0, 1, 5'd11, 1, 64'hDEAD_BEEF_DEAD_BEEF, "R4");
    step(0, 5'd10, 1, 5'd11, 0, 0, 0, 0, 64'h0, "R4");
    step(1, 5'd11, 1, 5'd12, 1, 0, 0, 0, 64'h0, "R4");
    // R6: single write over a 64-bit value keeps upper half
    step(1, 0, 0, 0, 0, 1, 5'd20, 1, 64'h5555_6666_7777_8888, "");
    step(1, 0, 0, 0, 0, 1, 5'd20, 0, 64'hFFFF_FFFF_0000_1234, "");
    step(1, 5'd20, 1, 5'd20, 0, 0, 0, 0, 64'h0, "R6");
    // R8: mode change keeps data
    step(0, 5'd20, 0, 5'd3, 0, 0, 0, 0, 64'h0, "R8");
    step(1, 5'd10, 1, 5'd11, 1, 0, 0, 0, 64'h0, "R8");
    // R9: disabled write does nothing
    step(1, 0, 0, 0, 0, 0, 5'd20, 1, 64'h0BAD_0BAD_0BAD_0BAD, "R9");
    step(1, 5'd20, 1, 5'd20, 0, 0, 0, 0, 64'h0, "R9");
    // R7: pair write changes partner of a read register this cycle
    step(0, 5'd14, 1, 5'd15, 0, 1, 5'd14, 1, 64'h0102_0304_0506_0708, "R7");
    step(1, 5'd7, 1, 5'd7, 0, 1, 5'd7, 1, 64'h9999_8888_7777_6666, "R7");

    for (int n = 0; n < 1500; n++) begin
      logic [4:0] wi;
      wi = 5'($urandom_range(0, 31));
      step(1'($urandom), ($urandom_range(0, 3) == 0) ? wi : 5'($urandom),
           1'($urandom), 5'($urandom), 1'($urandom),
           1'($urandom), wi, 1'($urandom), {$urandom, $urandom}, "");
    end

    // R1: asynchronous reset mid-run
    @(negedge clk); we = 1'b0; mode = 1'b1; ra_dbl = 1'b1; ra_idx = 5'd7;
    rst_ni = 1'b0; #1;
    check(ra_data, 64'h0, "R1");
    ra_idx = 5'd20; #1;
    check(ra_data, 64'h0, "R1");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule